// File: doc/BRIEF.md
# Glitch-Free Card Clock Divider

This block derives a card clock from a reference clock. A 2-bit select picks one of four ratios: the reference itself, or the reference divided by 2, 4 or 8. A ratio change is never applied in the middle of a phase. The block waits until the current output has finished a whole low phase. It then keeps the line low for a guard interval and starts the new ratio with a full-width high phase. Because of this, no runt pulse can reach the card, whatever moment the select is changed.

A clock-enable input comes from the session sequencer and gates the output. While it is low, the card clock rests low. If it falls during a high phase, that phase still completes at full width. When it rises, the output starts with a whole high phase of the ratio selected at that moment. In pass-through mode the reference reaches the output through a latch-based clock gate. The gate opens and closes only while the reference is low, so a partial reference pulse is never passed. Reset is taken asynchronously and released in step with the reference clock.

Top module: `scd_card_clk`

## Requirements
- R1: Select codes map to ratios as follows: 2'b00 divides by 8, 2'b01 divides by 4, 2'b11 divides by 2, and 2'b10 passes the reference clock through (divide by 1).
- R2: In steady state at a ratio N of 2, 4 or 8, every high phase and every low phase of the card clock lasts exactly N/2 reference periods. At divide by 1, each phase lasts half a reference period.
- R3: A new select value takes effect only after the current output has completed a full low phase. The first high phase at the new ratio has the full width of that ratio.
- R4: Across a ratio change, the low level that spans the change lasts at least GUARD_CYC reference periods (default 8). No phase of the card clock is shorter than 45% of one reference period.
- R5: While the enable is low, the card clock stays low. If the enable falls during a high phase, that phase completes at its full width and no further high phase follows.
- R6: When the enable rises, the card clock begins with a full high phase of the ratio selected at that moment, including a select changed while the block was disabled.
- R7: During reset the card clock is low. After reset, with the enable high, the first high phase has full width.
- R8: Entering or leaving pass-through mode, or disabling while in it, never produces a partial reference pulse, and the pass-through gate is never open while the divided level is high.
- R9: When a select change and a falling enable reach the same low-phase boundary, the disable wins and no high phase is produced. On re-enable, the output starts with a full high phase of the newly selected ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Ratio select (encoding in R1) |
| clk_en | input | 1 | Card clock enable from the session sequencer |
| card_clk | output | 1 | Divided, gated card clock |

## Verification
The two functions that can fall in the same cycle are a pending ratio change and a disable, both resolved at the boundary where a low phase ends. The bench brings them together as follows. In divide-by-4 mode it waits for a rising edge of the card clock, counts four reference falling edges, then drops the enable and moves the select to pass-through, all on the same edge. It then judges that no high phase appears afterwards. It also checks that re-enabling starts with a full pass-through pulse and not with the ratio that was abandoned. Every phase width is measured in real time against the ratio expected from the table.

// File: rtl/scd_pkg.sv
package scd_pkg;

  // Ratio select codes; neighbouring ratios differ in one bit
  typedef enum logic [1:0] {
    SEL_DIV8 = 2'b00,
    SEL_DIV4 = 2'b01,
    SEL_DIV2 = 2'b11,
    SEL_DIV1 = 2'b10
  } div_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_GUARD = 2'd2
  } seq_state_e;

endpackage

// File: rtl/scd_rst_sync.sv
module scd_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_no = out_q;

endmodule

// File: rtl/scd_ratio_decode.sv
module scd_ratio_decode
  import scd_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic [1:0]       code_i,
  output logic [CNT_W-1:0] half_m1_o,
  output logic             pass_o
);

  // half_m1_o: reference cycles per phase, minus one
  always_comb begin
    half_m1_o = '0;
    pass_o    = 1'b0;
    case (code_i)
      SEL_DIV8: half_m1_o = CNT_W'(3);
      SEL_DIV4: half_m1_o = CNT_W'(1);
      SEL_DIV2: half_m1_o = CNT_W'(0);
      default:  pass_o    = 1'b1;
    endcase
  end

endmodule

// File: rtl/scd_clk_gate.sv
module scd_clk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic open_o,
  output logic clk_o
);

  logic en_lat;

  // Transparent only while the clock is low, so the gate can change state
  // only between reference pulses
  always_latch begin
    if (!rst_ni) begin
      en_lat <= 1'b0;
    end else if (!clk_i) begin
      en_lat <= en_i;
    end
  end

  assign open_o = en_lat;
  assign clk_o  = clk_i & en_lat;

endmodule

// File: rtl/scd_phase_seq.sv
module scd_phase_seq
  import scd_pkg::*;
#(
  parameter int GUARD_CYC = 8,
  parameter int CNT_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       sel_i,
  input  logic [CNT_W-1:0] new_half_m1_i,
  input  logic             new_pass_i,
  input  logic [CNT_W-1:0] cur_half_m1_i,
  input  logic             cur_pass_i,
  output logic [1:0]       ratio_o,
  output logic             div_lvl_o,
  output logic             gate_req_o
);

  localparam logic [CNT_W-1:0] GUARD_LOAD = CNT_W'(GUARD_CYC);

  seq_state_e       state_q, state_d;
  logic [1:0]       ratio_q, ratio_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             div_q, div_d;
  logic             gate_q, gate_d;
  logic             sel_moved;

  assign sel_moved = (sel_i != ratio_q);

  always_comb begin
    state_d = state_q;
    ratio_d = ratio_q;
    cnt_d   = cnt_q;
    div_d   = div_q;
    gate_d  = gate_q;
    case (state_q)
      ST_IDLE: begin
        if (en_i) begin
          state_d = ST_RUN;
          ratio_d = sel_i;
          if (new_pass_i) begin
            gate_d = 1'b1;
          end else begin
            div_d = 1'b1;
            cnt_d = new_half_m1_i;
          end
        end
      end
      ST_RUN: begin
        if (cur_pass_i) begin
          // every reference cycle is a phase boundary in pass-through
          if (!en_i) begin
            gate_d  = 1'b0;
            state_d = ST_IDLE;
          end else if (sel_moved) begin
            gate_d  = 1'b0;
            state_d = ST_GUARD;
            cnt_d   = GUARD_LOAD;
          end
        end else if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (div_q) begin
          // high phase complete
          div_d = 1'b0;
          cnt_d = cur_half_m1_i;
          if (!en_i) begin
            state_d = ST_IDLE;
          end
        end else begin
          // low phase complete: the only point where a change is applied
          if (!en_i) begin
            state_d = ST_IDLE;
          end else if (sel_moved) begin
            state_d = ST_GUARD;
            cnt_d   = GUARD_LOAD;
          end else begin
            div_d = 1'b1;
            cnt_d = cur_half_m1_i;
          end
        end
      end
      ST_GUARD: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (!en_i) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_RUN;
          ratio_d = sel_i;
          if (new_pass_i) begin
            gate_d = 1'b1;
          end else begin
            div_d = 1'b1;
            cnt_d = new_half_m1_i;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        div_d   = 1'b0;
        gate_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ratio_q <= SEL_DIV8;
      cnt_q   <= '0;
      div_q   <= 1'b0;
      gate_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ratio_q <= ratio_d;
      cnt_q   <= cnt_d;
      div_q   <= div_d;
      gate_q  <= gate_d;
    end
  end

  assign ratio_o    = ratio_q;
  assign div_lvl_o  = div_q;
  assign gate_req_o = gate_q;

endmodule

// File: rtl/scd_card_clk.sv
module scd_card_clk #(
  parameter int GUARD_CYC = 8
) (
  input  logic       clk_ref,
  input  logic       rst_n,
  input  logic [1:0] div_sel,
  input  logic       clk_en,
  output logic       card_clk
);

  localparam int GUARD_W = $clog2(GUARD_CYC + 1);
  localparam int CNT_W   = (GUARD_W > 2) ? GUARD_W : 2;

  logic             rst_sync_n;
  logic [1:0]       ratio;
  logic [CNT_W-1:0] new_half_m1, cur_half_m1;
  logic             new_pass, cur_pass;
  logic             div_lvl;
  logic             gate_req;
  logic             gate_open;
  logic             gated_clk;

  scd_rst_sync u_rst (
    .clk_i       (clk_ref),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_sync_n)
  );

  scd_ratio_decode #(.CNT_W(CNT_W)) u_dec_new (
    .code_i    (div_sel),
    .half_m1_o (new_half_m1),
    .pass_o    (new_pass)
  );

  scd_ratio_decode #(.CNT_W(CNT_W)) u_dec_cur (
    .code_i    (ratio),
    .half_m1_o (cur_half_m1),
    .pass_o    (cur_pass)
  );

  scd_phase_seq #(.GUARD_CYC(GUARD_CYC), .CNT_W(CNT_W)) u_seq (
    .clk_i         (clk_ref),
    .rst_ni        (rst_sync_n),
    .en_i          (clk_en),
    .sel_i         (div_sel),
    .new_half_m1_i (new_half_m1),
    .new_pass_i    (new_pass),
    .cur_half_m1_i (cur_half_m1),
    .cur_pass_i    (cur_pass),
    .ratio_o       (ratio),
    .div_lvl_o     (div_lvl),
    .gate_req_o    (gate_req)
  );

  scd_clk_gate u_gate (
    .clk_i  (clk_ref),
    .rst_ni (rst_sync_n),
    .en_i   (gate_req),
    .open_o (gate_open),
    .clk_o  (gated_clk)
  );

  // the two sources are never active together, so an OR merges them cleanly
  assign card_clk = gated_clk | div_lvl;

endmodule

// File: rtl/scd_card_clk_chk.sv
module scd_card_clk_chk (
  input logic       clk_ref,
  input logic       rst_sync_n,
  input logic       clk_en,
  input logic [1:0] div_sel,
  input logic       div_lvl,
  input logic       gate_req,
  input logic       gate_open
);

  // R8
  no_overlap_chk: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
    !(div_lvl && gate_open));

  // R5
  held_low_chk: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
    (!clk_en && !div_lvl) |=> !div_lvl);

  // R5
  gate_drop_chk: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
    !clk_en |=> !gate_req);

  // R1
  pass_code_chk: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
    $rose(gate_req) |-> ($past(div_sel) == 2'b10));

  // R1
  div_code_chk: assert property (@(posedge clk_ref) disable iff (!rst_sync_n)
    $rose(div_lvl) |-> ($past(div_sel) != 2'b10));

endmodule

bind scd_card_clk scd_card_clk_chk u_chk (
  .clk_ref    (clk_ref),
  .rst_sync_n (rst_sync_n),
  .clk_en     (clk_en),
  .div_sel    (div_sel),
  .div_lvl    (div_lvl),
  .gate_req   (gate_req),
  .gate_open  (gate_open)
);

// File: tb/scd_card_clk_tb.sv
`timescale 1ns/1ps
module scd_card_clk_tb;

  localparam real TCK    = 5.0;
  localparam real HALF_U = 2.5;
  localparam real TOL    = 0.01;

  // {from select, to select, expected phase width of new ratio in 2.5 ns units}
  localparam logic [7:0] VEC [12] = '{
    {2'b00, 2'b01, 4'd4}, {2'b00, 2'b11, 4'd2}, {2'b00, 2'b10, 4'd1},
    {2'b01, 2'b00, 4'd8}, {2'b01, 2'b11, 4'd2}, {2'b01, 2'b10, 4'd1},
    {2'b11, 2'b00, 4'd8}, {2'b11, 2'b01, 4'd4}, {2'b11, 2'b10, 4'd1},
    {2'b10, 2'b00, 4'd8}, {2'b10, 2'b01, 4'd4}, {2'b10, 2'b11, 4'd2}
  };

  logic       clk_ref = 1'b0;
  logic       rst_n;
  logic [1:0] div_sel;
  logic       clk_en;
  logic       card_clk;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  realtime t_last = 0;
  real     min_ph, max_low, first_high, last_high, last_low;
  bit      mon_on = 1'b0, guard_seen, first_got;
  int      rise_cnt = 0;

  scd_card_clk u_dut (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .div_sel  (div_sel),
    .clk_en   (clk_en),
    .card_clk (card_clk)
  );

  always #(TCK/2) clk_ref = ~clk_ref;

  // phase-width monitor
  always @(card_clk) begin
    real w;
    w = $realtime - t_last;
    t_last = $realtime;
    if (mon_on) begin
      if (w < min_ph) min_ph = w;
      if (card_clk) begin
        rise_cnt++;
        last_low = w;
        if (w > max_low) max_low = w;
        if (w >= 8.0 * TCK - TOL) guard_seen = 1'b1;
      end else begin
        last_high = w;
        if (guard_seen && !first_got) begin
          first_high = w;
          first_got  = 1'b1;
        end
      end
    end
  end

  task automatic arm();
    min_ph     = 1.0e9;
    max_low    = 0.0;
    guard_seen = 1'b0;
    first_got  = 1'b0;
    first_high = 0.0;
  endtask

  task automatic check(input bit ok, input string tag, input real act, input real exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", tag, act, exp);
    end
  endtask

  function automatic bit near(input real a, input real b);
    return (a - b < TOL) && (b - a < TOL);
  endfunction

  task automatic cycles(input int n);
    repeat (n) @(negedge clk_ref);
  endtask

  initial begin
    repeat (200000) @(posedge clk_ref);
    if (!done) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int r0;
    rst_n   = 1'b1;
    div_sel = 2'b00;
    clk_en  = 1'b0;
    #1 rst_n = 1'b0;
    mon_on = 1'b1;
    arm();
    cycles(10);
    // R7: low during reset
    check(card_clk == 1'b0 && rise_cnt == 0, "R7 reset level", real'(rise_cnt), 0.0);
    rst_n = 1'b1;
    cycles(5);
    clk_en = 1'b1;
    cycles(30);
    // R7 / R6: first pulse after reset is full divide-by-8 width
    check(first_got && near(first_high, 8 * HALF_U), "R7 first high after reset",
          first_high, 8 * HALF_U);

    // table of all ordered select transitions
    for (int i = 0; i < 12; i++) begin
      logic [1:0] from_s, to_s;
      real        exp_w;
      from_s = VEC[i][7:6];
      to_s   = VEC[i][5:4];
      exp_w  = real'(VEC[i][3:0]) * HALF_U;
      div_sel = from_s;
      cycles(60);
      arm();
      div_sel = to_s;
      cycles(60);
      // R3: first high of the new ratio is full width
      check(first_got && near(first_high, exp_w), $sformatf("R3 vec %0d first high", i),
            first_high, exp_w);
      // R4: guard low and no runt
      check(max_low >= 8.0 * TCK - TOL, $sformatf("R4 vec %0d guard low", i),
            max_low, 8.0 * TCK);
      check(min_ph >= 0.45 * TCK, $sformatf("R4 vec %0d min phase", i), min_ph, 0.45 * TCK);
      // R1 / R2: steady widths match the new code
      check(near(last_high, exp_w), $sformatf("R1 vec %0d steady high", i), last_high, exp_w);
      check(near(last_low, exp_w), $sformatf("R2 vec %0d steady low", i), last_low, exp_w);
    end

    // R5: disable during a divide-by-8 high phase
    div_sel = 2'b00;
    cycles(60);
    @(posedge card_clk);
    @(negedge clk_ref);
    clk_en = 1'b0;
    arm();
    r0 = rise_cnt;
    cycles(40);
    check(near(last_high, 8 * HALF_U), "R5 high completes", last_high, 8 * HALF_U);
    check(rise_cnt == r0 && card_clk == 1'b0, "R5 held low", real'(rise_cnt - r0), 0.0);

    // R6: select changed while disabled, then enable
    div_sel = 2'b01;
    cycles(5);
    arm();
    clk_en = 1'b1;
    cycles(30);
    check(first_got && near(first_high, 4 * HALF_U), "R6 restart width",
          first_high, 4 * HALF_U);

    // R8: disable and re-enable in pass-through
    div_sel = 2'b10;
    cycles(40);
    check(near(last_high, HALF_U), "R1 pass-through high", last_high, HALF_U);
    arm();
    r0 = rise_cnt;
    clk_en = 1'b0;
    cycles(20);
    check(rise_cnt - r0 <= 1 && card_clk == 1'b0, "R8 stop pass-through",
          real'(rise_cnt - r0), 1.0);
    check(min_ph >= 0.45 * TCK, "R8 stop no runt", min_ph, 0.45 * TCK);
    arm();
    clk_en = 1'b1;
    cycles(20);
    check(first_got && near(first_high, HALF_U), "R8 restart pass-through",
          first_high, HALF_U);
    check(min_ph >= 0.45 * TCK, "R8 restart no runt", min_ph, 0.45 * TCK);

    // R9: select change and disable meet at a low-phase boundary
    div_sel = 2'b01;
    cycles(60);
    @(posedge card_clk);
    repeat (4) @(negedge clk_ref);
    clk_en  = 1'b0;
    div_sel = 2'b10;
    arm();
    r0 = rise_cnt;
    cycles(40);
    check(rise_cnt == r0 && card_clk == 1'b0, "R9 disable wins",
          real'(rise_cnt - r0), 0.0);
    arm();
    clk_en = 1'b1;
    cycles(20);
    check(first_got && near(first_high, HALF_U), "R9 restart uses new select",
          first_high, HALF_U);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule